// File: doc/BRIEF.md
# Serial Access-Code Security Sequencer

This block guards a bank of memories by standing in their data path until a caller proves it knows a secret. While locked, it holds the memory pass-through enable low, so chip enables never reach the RAMs. To open the lock, a caller first arms the sequencer. Arming happens either through a reset pulse or through one throwaway read cycle. The caller then writes a code one bit per write cycle on a single data line. If the code equals the built-in key, the caller reads back a built-in identifier, one bit per read cycle. After the last identifier bit, the block opens and memory cycles pass through.

The width of the code, the key and the identifier are synthesis parameters. The key is only compared and never driven out. Cycle boundaries come from the active-low chip enable, read strobe and write strobe, which are sampled on the block clock. The data line is brought out as a separate input, output and output enable, so that a pad can form the bidirectional pin. Either of two events relocks the block: loss of power-good or the active-low reset.

Top module: `serial_code_lock`

## Requirements
- R1: While `rstN` is low, `memEnable` and `dataOe` are 0. After reset is released, the sequencer accepts code writes at once, with no dummy read.
- R2: When the block is locked and idle after power-good returns, write cycles are ignored. One complete read cycle (`ceN` and `rdN` both low, then either rises) arms the code-write phase.
- R3: A write cycle is a span where `ceN` and `weN` are both low. It ends when the first of the two rises. Its bit is the `dataIn` value seen on the last clock edge before that rise. The first write supplies key bit 0 (least-significant bit first).
- R4: A read cycle during the code-write phase, before the last code bit is written, aborts to the idle locked state.
- R5: After the last code write, a code that differs from the key in any bit returns the block to idle. An exact match enters the identifier phase.
- R6: In the identifier phase, during the k-th read cycle (counting from 0), `dataOe` is 1 and `dataOut` equals identifier bit k while `ceN` and `rdN` are both low.
- R7: A write cycle during the identifier phase returns the block to idle.
- R8: `memEnable` becomes 1 only after the last identifier read cycle ends. It stays 1 while power is good and reset is high.
- R9: When `powerGood` is low, `memEnable` is 0 in the same cycle and the block relocks to idle. Reopening then needs a dummy read and the full sequence.
- R10: When `rstN` goes low while the block is open, `memEnable` drops at once and the block relocks.
- R11: `dataOe` is 0 outside identifier-phase read cycles, including reads while the block is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the strobes |
| rstN | input | 1 | Active-low asynchronous reset; relocks the block and arms the sequence |
| powerGood | input | 1 | High while supply is in tolerance; low relocks the block |
| ceN | input | 1 | Active-low chip enable from the host |
| rdN | input | 1 | Active-low read strobe |
| weN | input | 1 | Active-low write strobe |
| dataIn | input | 1 | Data line value seen at the pad |
| dataOut | output | 1 | Identifier bit to drive onto the data line |
| dataOe | output | 1 | Drive enable for the data line pad |
| memEnable | output | 1 | Memory pass-through enable; high only when unlocked |

## Verification
The sequencing is tried with several input patterns:
- The exact key, to show that capture order and compare are right.
- Every single-bit corruption of the key, which isolates each compare bit.
- An aborting read placed after every possible count of code writes, followed by the remaining key bits, which shows that the abort really clears the sequence and does not merely pause it.
- A write placed after every possible count of identifier reads, which separates a true relock from a skipped bit.

Write cycles alternate between ending on chip enable and ending on write strobe. The data line flips at the ending edge, so a capture taken after the first rising strobe would corrupt the code. Power-good loss and reset while open, and an identifier read that stops one short of the end, bound the opening condition.

// File: rtl/serial_code_lock_pkg.sv
package serial_code_lock_pkg;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ARMED = 2'd1,
    LK_IDENT = 2'd2,
    LK_OPEN  = 2'd3
  } lockState_t;

  typedef struct packed {
    logic captureEn;
    logic shiftEn;
    logic stepEn;
    logic clearEn;
  } dpStrobe_t;

endpackage

// File: rtl/serial_code_lock_dp.sv
module serial_code_lock_dp
  import serial_code_lock_pkg::*;
#(
  parameter int CODE_BITS = 64,
  parameter logic [CODE_BITS-1:0] KEY = '0,
  parameter logic [CODE_BITS-1:0] IDENT = '0
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      dataIn,
  output logic      codeMatch,
  output logic      countLast,
  output logic      identBit
);

  localparam int CW = (CODE_BITS > 1) ? $clog2(CODE_BITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(CODE_BITS - 1);

  logic                 sampleBit;
  logic [CODE_BITS-1:0] shiftReg;
  logic [CODE_BITS-1:0] shiftNext;
  logic [CW-1:0]        bitCount;

  // newest bit enters at the top, so the first bit lands in position 0
  if (CODE_BITS > 1) begin : g_wide
    assign shiftNext = {sampleBit, shiftReg[CODE_BITS-1:1]};
  end else begin : g_single
    assign shiftNext = sampleBit;
  end

  assign codeMatch = (shiftNext == KEY);
  assign countLast = (bitCount == LAST_IDX);
  assign identBit  = IDENT[bitCount];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleBit <= 1'b0;
      shiftReg  <= '0;
      bitCount  <= '0;
    end else begin
      if (strobe.captureEn) sampleBit <= dataIn;
      if (strobe.shiftEn)   shiftReg  <= shiftNext;
      if (strobe.clearEn)     bitCount <= '0;
      else if (strobe.stepEn) bitCount <= bitCount + CW'(1);
    end
  end

  // R3: each accepted bit advances the position by exactly one
  a_r3_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && !strobe.clearEn) |=> (bitCount == $past(bitCount) + CW'(1)));

  // R6: a cleared position starts the next phase at bit 0
  a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearEn |=> (bitCount == '0));

endmodule

// File: rtl/serial_code_lock_ctrl.sv
module serial_code_lock_ctrl
  import serial_code_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerGood,
  input  logic      ceN,
  input  logic      rdN,
  input  logic      weN,
  input  logic      codeMatch,
  input  logic      countLast,
  output dpStrobe_t strobe,
  output logic      dataOe,
  output logic      memEnable
);

  lockState_t state;
  lockState_t stateNext;
  logic wrActive, rdActive;
  logic wrPrev, rdPrev;
  logic wrEnd, rdEnd;

  assign wrActive = !ceN && !weN;
  assign rdActive = !ceN && !rdN;
  assign wrEnd    = wrPrev && !wrActive;
  assign rdEnd    = rdPrev && !rdActive;

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.captureEn = wrActive;
    if (!powerGood) begin
      stateNext      = LK_IDLE;
      strobe.clearEn = 1'b1;
    end else begin
      unique case (state)
        LK_IDLE: begin
          if (rdEnd) begin
            stateNext      = LK_ARMED;
            strobe.clearEn = 1'b1;
          end
        end
        LK_ARMED: begin
          if (rdEnd) begin
            stateNext      = LK_IDLE;
            strobe.clearEn = 1'b1;
          end else if (wrEnd) begin
            strobe.shiftEn = 1'b1;
            if (countLast) begin
              strobe.clearEn = 1'b1;
              stateNext      = codeMatch ? LK_IDENT : LK_IDLE;
            end else begin
              strobe.stepEn = 1'b1;
            end
          end
        end
        LK_IDENT: begin
          if (wrEnd) begin
            stateNext      = LK_IDLE;
            strobe.clearEn = 1'b1;
          end else if (rdEnd) begin
            if (countLast) begin
              stateNext      = LK_OPEN;
              strobe.clearEn = 1'b1;
            end else begin
              strobe.stepEn = 1'b1;
            end
          end
        end
        LK_OPEN: ;
        default: stateNext = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= LK_ARMED;
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      state  <= stateNext;
      wrPrev <= wrActive;
      rdPrev <= rdActive;
    end
  end

  assign dataOe    = (state == LK_IDENT) && rdActive && powerGood;
  assign memEnable = (state == LK_OPEN) && powerGood;

  // R9: loss of power-good always relocks
  a_r9_power_relock: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (state == LK_IDLE));

  // R4: a read during the code phase aborts
  a_r4_read_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && state == LK_ARMED && rdEnd) |=> (state == LK_IDLE));

  // R7: a write during the identifier phase relocks
  a_r7_write_relocks: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && state == LK_IDENT && wrEnd) |=> (state == LK_IDLE));

  // R8: once open, stays open while power is good
  a_r8_open_holds: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && state == LK_OPEN) |=> (state == LK_OPEN));

  // R11: the data line is never driven while memory is passed through
  a_r11_no_drive_when_open: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !memEnable);

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import serial_code_lock_pkg::*;
#(
  parameter int CODE_BITS = 64,
  parameter logic [CODE_BITS-1:0] KEY = 64'hC3A5_1E0F_96D2_4B78,
  parameter logic [CODE_BITS-1:0] IDENT = 64'h0123_4567_89AB_CDEF
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic ceN,
  input  logic rdN,
  input  logic weN,
  input  logic dataIn,
  output logic dataOut,
  output logic dataOe,
  output logic memEnable
);

  dpStrobe_t strobe;
  logic codeMatch, countLast, identBit;

  serial_code_lock_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerGood (powerGood),
    .ceN       (ceN),
    .rdN       (rdN),
    .weN       (weN),
    .codeMatch (codeMatch),
    .countLast (countLast),
    .strobe    (strobe),
    .dataOe    (dataOe),
    .memEnable (memEnable)
  );

  serial_code_lock_dp #(
    .CODE_BITS (CODE_BITS),
    .KEY       (KEY),
    .IDENT     (IDENT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .codeMatch (codeMatch),
    .countLast (countLast),
    .identBit  (identBit)
  );

  assign dataOut = dataOe ? identBit : 1'b0;

endmodule

// File: tb/serial_code_lock_bench.sv
module serial_code_lock_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] BKEY = 8'h96;
  localparam logic [W-1:0] BID  = 8'h3C;

  logic clk = 1'b0;
  logic rstN, powerGood, ceN, rdN, weN, dataIn;
  logic dataOut, dataOe, memEnable;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  serial_code_lock #(.CODE_BITS(W), .KEY(BKEY), .IDENT(BID)) u_serial_code_lock (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .ceN(ceN), .rdN(rdN),
    .weN(weN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .memEnable(memEnable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeBit(input logic b, input bit ceFirst);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; dataIn = b;
    @(negedge clk);
    @(negedge clk);
    if (ceFirst) ceN = 1'b1; else weN = 1'b1;
    dataIn = ~b;
    @(negedge clk); ceN = 1'b1; weN = 1'b1; dataIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) writeBit(v[i], (i % 2) == 0);
  endtask

  task automatic readCycle(output logic oe, output logic bv);
    @(negedge clk); ceN = 1'b0; rdN = 1'b0;
    @(negedge clk); oe = dataOe; bv = dataOut;
    @(negedge clk); ceN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readIdents(input int n);
    logic oe, bv;
    for (int k = 0; k < n; k++) begin
      readCycle(oe, bv);
      check("R6 identifier drive", oe, 1);
      check("R6 identifier bit", bv, BID[k]);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    logic oe, bv;
    int driven;
    rstN = 1'b0; powerGood = 1'b1; ceN = 1'b1; rdN = 1'b1; weN = 1'b1; dataIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset memEnable", memEnable, 0);
    check("R1 reset dataOe", dataOe, 0);
    rstN = 1'b1;

    // armed straight from reset: full key then identifier opens
    writeWord(BKEY, W);
    check("R1 no dummy read needed memEnable", memEnable, 0);
    readIdents(W);
    check("R3 key captured LSB first opens", memEnable, 1);
    readCycle(oe, bv);
    check("R11 read while open not driven", oe, 0);
    check("R8 open holds", memEnable, 1);

    // power-good loss relocks
    @(negedge clk); powerGood = 1'b0; #1;
    check("R9 memEnable drops", memEnable, 0);
    @(negedge clk); @(negedge clk); powerGood = 1'b1;
    writeWord(BKEY, W);
    driven = 0;
    for (int k = 0; k < W; k++) begin
      readCycle(oe, bv);
      driven += oe;
    end
    check("R9 no drive without fresh sequence", driven, 0);
    check("R9 still locked", memEnable, 0);

    // idle: junk writes ignored, dummy read arms
    writeWord(~BKEY, 3);
    readCycle(oe, bv);
    check("R2 dummy read not driven", oe, 0);
    writeWord(BKEY, W);
    readIdents(W);
    check("R2 dummy read arms", memEnable, 1);

    // every single-bit corruption of the key
    for (int i = 0; i < W; i++) begin
      pulseReset();
      writeWord(BKEY ^ (W'(1) << i), W);
      readCycle(oe, bv);
      check($sformatf("R5 mismatch bit %0d no drive", i), oe, 0);
      check($sformatf("R5 mismatch bit %0d locked", i), memEnable, 0);
    end

    // abort after every partial count
    for (int n = 1; n < W; n++) begin
      pulseReset();
      writeWord(BKEY, n);
      readCycle(oe, bv);
      check($sformatf("R4 abort read %0d no drive", n), oe, 0);
      writeWord(BKEY >> n, W - n);
      readCycle(oe, bv);
      check($sformatf("R4 abort after %0d writes holds", n), oe, 0);
      check($sformatf("R4 abort after %0d locked", n), memEnable, 0);
    end

    // write during identifier phase after every read count
    for (int k = 0; k < W; k++) begin
      pulseReset();
      writeWord(BKEY, W);
      readIdents(k);
      writeBit(1'b0, 1'b0);
      readCycle(oe, bv);
      check($sformatf("R7 write after %0d reads no drive", k), oe, 0);
      check($sformatf("R7 write after %0d reads locked", k), memEnable, 0);
    end

    // open only after the last identifier read
    pulseReset();
    writeWord(BKEY, W);
    readIdents(W - 1);
    check("R8 one read short locked", memEnable, 0);
    readIdents(1);
    check("R8 last read opens", memEnable, 1);

    // reset while open
    @(negedge clk); rstN = 1'b0; #1;
    check("R10 reset drops memEnable", memEnable, 0);
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    check("R10 relocked after reset", memEnable, 0);
    writeWord(BKEY, W);
    readIdents(W);
    check("R10 sequence after reset opens", memEnable, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule